// File: doc/BRIEF.md
# Carry-Skip Group Adder

A combinational two-operand binary adder with carry-in and carry-out. The operand width is cut into equal groups. Inside each group the carry ripples one bit at a time. Each group also has a skip path: when every bit of the group propagates, the group's incoming carry is steered straight to its outgoing carry by a two-way multiplexer. A carry that crosses several fully propagating groups then passes one multiplexer per group instead of every bit position.

A first stage forms per-bit generate (a AND b) and propagate (a XOR b) from the operands alone. The group stage forms the carry into every bit and the carry out of every group. A final stage forms each sum bit as the propagate bit XOR the carry into that bit. The block sits in a datapath as a drop-in replacement for a ripple adder. It has no clock and no state. `WIDTH` sets the operand width (default 16) and `GROUP` sets the group size (default 4). Elaboration stops when `WIDTH` is not a whole multiple of `GROUP`.

Top module: `csk_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals a_i + b_i + cin_i, computed as a WIDTH+1 bit unsigned sum.
- R2: Inside a group, a bit with a_i and b_i both 1 produces a carry into the next bit. A bit with both 0 blocks the carry into the next bit. A bit with exactly one of them set passes its incoming carry on.
- R3: Group k covers bits GROUP*k through GROUP*k+GROUP-1, so with the defaults it covers 0–3, 4–7, 8–11 and 12–15. When all of its bits have a_i XOR b_i = 1, its carry-out equals its carry-in.
- R4: When a group has at least one bit with a_i XOR b_i = 0, its carry-out equals the carry that leaves its top bit through the ripple path.
- R5: Sum bit i equals (a_i[i] XOR b_i[i]) XOR the carry into bit i. The carry into bit 0 is cin_i.
- R6: When a_i XOR b_i is all ones, a carry-in of 1 gives sum_o = 0 and cout_o = 1, and a carry-in of 0 gives sum_o all ones and cout_o = 0.
- R7: All-zero operands with carry-in 0 give a zero sum and cout_o = 0. All-ones operands with carry-in 1 give sum_o all ones and cout_o = 1.
- R8: Elaboration fails unless WIDTH is a multiple of GROUP. The number of groups is WIDTH/GROUP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that travels through the skip multiplexers of one or more fully propagating groups. The group below them must generate the carry or take it from cin_i, and the group above must consume it. Random operands almost never make all of a group's bits propagate. The bench therefore builds operands per group: chosen groups get complementary bit patterns so that they skip, and the neighbouring groups generate, kill or pass the carry on. Every result is compared with a behavioural addition.

// File: rtl/csk_pkg.sv
package csk_pkg;
  localparam int unsigned CSK_WIDTH = 16;
  localparam int unsigned CSK_GROUP = 4;
endpackage

// File: rtl/csk_pg_setup.sv
module csk_pg_setup #(
  parameter int unsigned WIDTH = csk_pkg::CSK_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] gen_o
);
  always_comb begin
    prop_o = a_i ^ b_i;
    gen_o  = a_i & b_i;
  end
endmodule

// File: rtl/csk_skip_group.sv
module csk_skip_group #(
  parameter int unsigned GROUP = csk_pkg::CSK_GROUP
) (
  input  logic [GROUP-1:0] prop_i,
  input  logic [GROUP-1:0] gen_i,
  input  logic             cin_i,
  output logic [GROUP-1:0] bit_cin_o,
  output logic             cout_o
);
  logic [GROUP:0] rc;
  logic           skip;

  always_comb begin
    rc[0] = cin_i;
    for (int j = 0; j < GROUP; j++) begin
      rc[j+1] = gen_i[j] | (prop_i[j] & rc[j]);
    end
  end

  assign bit_cin_o = rc[GROUP-1:0];
  assign skip      = &prop_i;
  assign cout_o    = skip ? cin_i : rc[GROUP];

  // R2: per-bit generate forces, kill blocks the next carry
  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      if (gen_i[j]) a_r2_gen_carries: assert (rc[j+1]);
      if (!gen_i[j] && !prop_i[j]) a_r2_kill_blocks: assert (!rc[j+1]);
    end
  end

  // R3: the skip path and the ripple path agree when skipping
  always_comb begin
    if (skip) a_r3_skip_matches_ripple: assert (rc[GROUP] == cin_i && cout_o == cin_i);
  end

  // R4: without skip the group carry-out is the ripple result
  always_comb begin
    if (!skip) a_r4_noskip_is_ripple: assert (cout_o == rc[GROUP]);
  end
endmodule

// File: rtl/csk_sum.sv
module csk_sum #(
  parameter int unsigned WIDTH = csk_pkg::CSK_WIDTH
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o
);
  assign sum_o = prop_i ^ carry_i;
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
  parameter int unsigned WIDTH = csk_pkg::CSK_WIDTH,
  parameter int unsigned GROUP = csk_pkg::CSK_GROUP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NGRP = WIDTH / GROUP;

  // R8: width must split into whole groups
  if ((WIDTH % GROUP) != 0 || GROUP == 0) begin : g_bad_split
    $error("csk_adder: WIDTH must be a multiple of GROUP");
  end

  logic [WIDTH-1:0] prop, gen, bit_carry;
  logic [NGRP:0]    grp_carry;

  csk_pg_setup #(.WIDTH(WIDTH)) u_setup (
    .a_i    (a_i),
    .b_i    (b_i),
    .prop_o (prop),
    .gen_o  (gen)
  );

  assign grp_carry[0] = cin_i;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    csk_skip_group #(.GROUP(GROUP)) u_grp (
      .prop_i    (prop[k*GROUP +: GROUP]),
      .gen_i     (gen[k*GROUP +: GROUP]),
      .cin_i     (grp_carry[k]),
      .bit_cin_o (bit_carry[k*GROUP +: GROUP]),
      .cout_o    (grp_carry[k+1])
    );
  end

  csk_sum #(.WIDTH(WIDTH)) u_sum (
    .prop_i  (prop),
    .carry_i (bit_carry),
    .sum_o   (sum_o)
  );

  assign cout_o = grp_carry[NGRP];

  // R1: whole result equals behavioural addition
  always_comb begin
    a_r1_matches_add: assert ({cout_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
  end

  // R6: full propagate carries cin straight through
  always_comb begin
    if (&(a_i ^ b_i)) a_r6_full_prop: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}});
  end
endmodule

// File: tb/csk_adder_tb_top.sv
`timescale 1ns/1ps
module csk_adder_tb_top;
  localparam int unsigned W = 16;
  localparam int unsigned G = 4;
  localparam int unsigned NG = W / G;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b, sum;
  logic cin, cout;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1bad_5eed;

  always #2.5 clk = ~clk;

  csk_adder #(.WIDTH(W), .GROUP(G)) dut_i (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  task automatic fin();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected < 100000", cycles);
      fin();
    end
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string req);
    logic [W:0] exp;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    #1;
    exp = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual %h expected %h",
               req, av, bv, cv, {cout, sum}, exp);
    end
  endtask

  task automatic t_reset();
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({cout, sum} !== '0) begin
      errors++;
      $display("FAIL R7 reset: actual %h expected 0", {cout, sum});
    end
    rst_ni = 1'b1;
  endtask

  task automatic t_corners();
    apply('0, '0, 1'b0, "R7 zeros");
    apply('1, '1, 1'b1, "R7 ones");
    apply('1, '1, 1'b0, "R7 ones no cin");
    apply(16'hA5C3, 16'h5A3C, 1'b1, "R6 full prop cin1");
    apply(16'hA5C3, 16'h5A3C, 1'b0, "R6 full prop cin0");
    apply(16'hFFFF, 16'h0000, 1'b1, "R6 all-ones plus cin");
    apply(16'hFFFF, 16'h0001, 1'b0, "R2 ripple full length");
  endtask

  // each group either skips, generates, kills or is random
  task automatic t_groups();
    for (int m = 0; m < 256; m++) begin
      logic [W-1:0] av, bv;
      for (int k = 0; k < NG; k++) begin
        logic [G-1:0] x;
        seed = nxt(seed);
        x = seed[G-1:0];
        case ((m >> (2*k)) & 3)
          0: begin av[k*G +: G] = x;        bv[k*G +: G] = ~x; end
          1: begin av[k*G +: G] = x | 4'h1; bv[k*G +: G] = ~x | 4'h1; end
          2: begin av[k*G +: G] = x & 4'hE; bv[k*G +: G] = ~x & 4'hE; end
          default: begin av[k*G +: G] = x;  bv[k*G +: G] = seed[2*G-1:G]; end
        endcase
      end
      apply(av, bv, m[0] ^ m[4], "R3 R4 group skip pattern");
    end
    // carry made in group 0 must skip groups 1..3 (R3 boundaries)
    apply(16'h555F, 16'hAAA1, 1'b0, "R3 skip groups 1-3");
    apply(16'h0F0F, 16'hF0F1, 1'b0, "R3 alternate skip");
    apply(16'h0008, 16'h0008, 1'b0, "R4 carry at group edge");
    apply(16'h0800, 16'h0800, 1'b1, "R5 sum bit with cin");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      seed = nxt(seed);
      apply(seed[15:0], seed[31:16], seed[7] ^ seed[20], "R1 random");
    end
  endtask

  initial begin
    t_reset();
    t_corners();
    t_groups();
    t_random();
    fin();
  end
endmodule